// File: doc/BRIEF.md
# Set/Clear Register Interrupt Gate

A generic register bank for a peripheral on a 32-bit, word-only register bus. It holds a command register that turns written ones into single-cycle pulses, a read/write mode register, a bank of feature enables and an interrupt mask. The feature enables and the interrupt mask are each changed only through a pair of set and clear addresses. This gives atomic bit updates with no read-modify-write. The interrupt line is the OR of the peripheral's status bits after masking, so software can enable or silence any source with a single write.

The bus has no back-pressure. A write is taken in the cycle its strobe is high. A read strobe loads the read data register at the next edge, and the value then holds until the next read. The bus never stalls, so no ready signal exists. The status, command, mode, enable and interrupt pins are plain level signals with no handshake.

Word map (address bits [1:0] are ignored): 0x00 command, 0x04 mode, 0x08 feature set, 0x0C feature clear, 0x10 feature enables, 0x14 mask set, 0x18 mask clear, 0x1C mask, 0x20 raw status. All other words are unmapped.

Top module: `sc_irq_regbank`

## Requirements
- R1: Writing to word 0x00 drives `cmd_o` with the low N_CMD bits of the written data for exactly the one cycle after the write edge. `cmd_o` is zero in every other cycle, and a zero bit gives no pulse.
- R2: Writing to word 0x08 sets each feature-enable bit whose written bit is 1 and leaves bits written 0 unchanged. The result is visible on `feat_o` and at word 0x10.
- R3: Writing to word 0x0C clears each feature-enable bit whose written bit is 1 and leaves bits written 0 unchanged.
- R4: Word 0x04 is read/write and holds MODE_W bits, which appear on `mode_o`. It is zero after reset and changes only when word 0x04 is written.
- R5: The interrupt mask is set bitwise by ones written to word 0x14 and cleared bitwise by ones written to word 0x18. It reads back at word 0x1C.
- R6: `irq_o` is high in the same cycle exactly when some bit of `status_i` and the same mask bit are both 1. The raw `status_i` reads back at word 0x20.
- R7: Reads of the write-only words 0x00, 0x08, 0x0C, 0x14 and 0x18 return zero. Unmapped words also read zero, and bits above a register's width read zero. Writes to read-only or unmapped words change nothing.
- R8: `rdata_o` takes the selected value at the edge where `rd_en_i` is high, and holds it until the next read.
- R9: Address bits [1:0] take no part in decoding.
- R10: Reset (`rst_n` low, asynchronous) clears the feature enables, the mask, the mode, `cmd_o` and `rdata_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | DATA_W | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | DATA_W | Registered read data |
| status_i | input | N_IRQ | Peripheral status bits |
| cmd_o | output | N_CMD | One-cycle command pulses |
| mode_o | output | MODE_W | Mode register value |
| feat_o | output | N_FEAT | Feature enable vector |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W=8, N_CMD=8, MODE_W=16, N_FEAT=8 and N_IRQ=12. Every register is narrower than the bus, so writes with ones in the upper bits show that those bits are dropped and read back as zero. The 8-bit address space leaves word 0x24 unmapped, which gives an address for the unmapped-read and ignored-write checks. The 12-bit status and mask let the bench place a status bit both inside and outside the mask.

// File: rtl/sc_regbank_pkg.sv
package sc_regbank_pkg;
  // Word indices of the register map (byte address >> 2).
  localparam int unsigned REG_CMD   = 0;
  localparam int unsigned REG_MODE  = 1;
  localparam int unsigned REG_FSET  = 2;
  localparam int unsigned REG_FCLR  = 3;
  localparam int unsigned REG_FEN   = 4;
  localparam int unsigned REG_ISET  = 5;
  localparam int unsigned REG_ICLR  = 6;
  localparam int unsigned REG_IMASK = 7;
  localparam int unsigned REG_STAT  = 8;
  localparam int unsigned NREG      = 9;
endpackage

// File: rtl/sc_addr_decode.sv
module sc_addr_decode
  import sc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  output logic [NREG-1:0]   wsel_o
);
  localparam int unsigned WI = ADDR_W - 2;

  logic [WI-1:0] word;
  assign word = addr_i[ADDR_W-1:2]; // R9: byte lanes ignored

  for (genvar g = 0; g < NREG; g++) begin : g_sel
    assign wsel_o[g] = wr_en_i && (word == WI'(g));
  end
endmodule

// File: rtl/sc_setclr_reg.sv
module sc_setclr_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  // Clear takes priority if one bit is set and cleared together.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= (q_o | set_i) & ~clr_i;
  end

  // R2/R5: bits asked to set (and not cleared) are 1 afterwards
  a_r2_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));

  // R3/R5: bits asked to clear are 0 afterwards
  a_r3_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((q_o & $past(clr_i)) == '0));

  // R2/R3: bits written 0 keep their value
  a_r3_untouched_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((q_o ^ $past(q_o)) & ~$past(set_i | clr_i)) == '0));
endmodule

// File: rtl/sc_irq_gate.sv
module sc_irq_gate #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  assign irq_o = |(status_i & mask_i);

  // R6: a request needs a status bit and its mask bit together
  always_comb begin
    a_r6_irq_sources: assert (!irq_o || ((status_i != '0) && (mask_i != '0)));
  end
endmodule

// File: rtl/sc_irq_regbank.sv
module sc_irq_regbank
  import sc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CMD  = 8,
  parameter int unsigned MODE_W = 16,
  parameter int unsigned N_FEAT = 8,
  parameter int unsigned N_IRQ  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_IRQ-1:0]  status_i,
  output logic [N_CMD-1:0]  cmd_o,
  output logic [MODE_W-1:0] mode_o,
  output logic [N_FEAT-1:0] feat_o,
  output logic              irq_o
);
  localparam int unsigned WI = ADDR_W - 2;

  logic [NREG-1:0]   wsel;
  logic [WI-1:0]     word;
  logic [N_IRQ-1:0]  mask;
  logic [DATA_W-1:0] rd_val;

  assign word = addr_i[ADDR_W-1:2];

  sc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .wr_en_i(wr_en_i),
    .wsel_o (wsel)
  );

  // R2/R3: feature enables
  sc_setclr_reg #(.W(N_FEAT)) u_feat (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(wsel[REG_FSET] ? wdata_i[N_FEAT-1:0] : '0),
    .clr_i(wsel[REG_FCLR] ? wdata_i[N_FEAT-1:0] : '0),
    .q_o  (feat_o)
  );

  // R5: interrupt mask
  sc_setclr_reg #(.W(N_IRQ)) u_mask (
    .clk  (clk),
    .rst_n(rst_n),
    .set_i(wsel[REG_ISET] ? wdata_i[N_IRQ-1:0] : '0),
    .clr_i(wsel[REG_ICLR] ? wdata_i[N_IRQ-1:0] : '0),
    .q_o  (mask)
  );

  // R6
  sc_irq_gate #(.W(N_IRQ)) u_gate (
    .status_i(status_i),
    .mask_i  (mask),
    .irq_o   (irq_o)
  );

  // R1: command pulses, R4: mode register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_o  <= '0;
      mode_o <= '0;
    end else begin
      cmd_o <= wsel[REG_CMD] ? wdata_i[N_CMD-1:0] : '0;
      if (wsel[REG_MODE]) mode_o <= wdata_i[MODE_W-1:0];
    end
  end

  // R7: read mux; write-only and unmapped words return zero
  always_comb begin
    rd_val = '0;
    case (word)
      WI'(REG_MODE):  rd_val = DATA_W'(mode_o);
      WI'(REG_FEN):   rd_val = DATA_W'(feat_o);
      WI'(REG_IMASK): rd_val = DATA_W'(mask);
      WI'(REG_STAT):  rd_val = DATA_W'(status_i);
      default:        rd_val = '0;
    endcase
  end

  // R8: registered read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_val;
  end

  // R1: a pulse only follows a command write
  a_r1_cmd_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o != '0) |-> $past(wr_en_i && (addr_i[ADDR_W-1:2] == WI'(REG_CMD))));

  // R1: a pulse lasts one cycle unless written again
  a_r1_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_o != '0) && !(wr_en_i && (word == WI'(REG_CMD)))) |=> (cmd_o == '0));

  // R4: mode changes only on its own write
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en_i && (word == WI'(REG_MODE))) |=> $stable(mode_o));

  // R7: write-only words read zero
  a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && ((word == WI'(REG_CMD)) || (word == WI'(REG_FSET)) ||
                 (word == WI'(REG_FCLR)) || (word == WI'(REG_ISET)) ||
                 (word == WI'(REG_ICLR)))) |=> (rdata_o == '0));

  // R8: read data holds between reads
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/tb_sc_irq_regbank.sv
`timescale 1ns/1ps
module tb_sc_irq_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [11:0] status = '0;
  logic [7:0]  cmd;
  logic [15:0] mode;
  logic [7:0]  feat;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  sc_irq_regbank dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
    .status_i(status), .cmd_o(cmd), .mode_o(mode), .feat_o(feat), .irq_o(irq)
  );

  typedef struct packed {
    logic        rd;
    logic [7:0]  a;
    logic [31:0] d;
    logic [11:0] s;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 8'h08, 32'h0000_00A5, 12'h000, 32'h0},          // R2 set
    '{1'b1, 8'h10, 32'h0,         12'h000, 32'h0000_00A5},  // R2
    '{1'b0, 8'h0C, 32'h0000_0021, 12'h000, 32'h0},          // R3 clear
    '{1'b1, 8'h10, 32'h0,         12'h000, 32'h0000_0084},  // R3
    '{1'b0, 8'h08, 32'h0,         12'h000, 32'h0},          // R2 zeros
    '{1'b1, 8'h10, 32'h0,         12'h000, 32'h0000_0084},  // R2
    '{1'b0, 8'h08, 32'hFFFF_FF00, 12'h000, 32'h0},          // R7 upper bits
    '{1'b1, 8'h10, 32'h0,         12'h000, 32'h0000_0084},  // R7
    '{1'b0, 8'h04, 32'hDEAD_BEEF, 12'h000, 32'h0},          // R4
    '{1'b1, 8'h04, 32'h0,         12'h000, 32'h0000_BEEF},  // R4
    '{1'b0, 8'h14, 32'h0000_0F0F, 12'h000, 32'h0},          // R5 set
    '{1'b1, 8'h1C, 32'h0,         12'h000, 32'h0000_0F0F},  // R5
    '{1'b0, 8'h18, 32'h0000_0003, 12'h000, 32'h0},          // R5 clear
    '{1'b1, 8'h1C, 32'h0,         12'h000, 32'h0000_0F0C},  // R5
    '{1'b1, 8'h00, 32'h0,         12'h000, 32'h0},          // R7 cmd
    '{1'b1, 8'h08, 32'h0,         12'h000, 32'h0},          // R7 fset
    '{1'b1, 8'h0C, 32'h0,         12'h000, 32'h0},          // R7 fclr
    '{1'b1, 8'h14, 32'h0,         12'h000, 32'h0},          // R7 iset
    '{1'b1, 8'h18, 32'h0,         12'h000, 32'h0},          // R7 iclr
    '{1'b1, 8'h20, 32'h0,         12'hABC, 32'h0000_0ABC},  // R6 raw status
    '{1'b0, 8'h24, 32'hFFFF_FFFF, 12'h000, 32'h0},          // R7 unmapped
    '{1'b1, 8'h24, 32'h0,         12'h000, 32'h0},          // R7
    '{1'b0, 8'h10, 32'h0000_00FF, 12'h000, 32'h0},          // R7 read-only
    '{1'b1, 8'h10, 32'h0,         12'h000, 32'h0000_0084},  // R7
    '{1'b1, 8'h07, 32'h0,         12'h000, 32'h0000_BEEF},  // R9
    '{1'b0, 8'h17, 32'h0000_0030, 12'h000, 32'h0},          // R9 set via offset
    '{1'b1, 8'h1C, 32'h0,         12'h000, 32'h0000_0F3C}   // R9
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 feat", 32'(feat), 32'h0);
    check("R10 mode", 32'(mode), 32'h0);
    check("R10 cmd", 32'(cmd), 32'h0);
    check("R10 rdata", rdata, 32'h0);
    check("R10 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    rd(8'h1C, v); check("R10 mask", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      status = VEC[i].s;
      if (VEC[i].rd) begin
        rd(VEC[i].a, v);
        check($sformatf("table[%0d] R2-R9", i), v, VEC[i].e);
      end else begin
        wr(VEC[i].a, VEC[i].d);
      end
    end
    check("R2 feat_o", 32'(feat), 32'h84);
    check("R4 mode_o", 32'(mode), 32'hBEEF);

    // R8: read data holds without a read strobe
    status = 12'h555;
    rd(8'h20, v);
    status = 12'h0;
    repeat (2) @(negedge clk);
    check("R8 hold", rdata, 32'h555);

    // R1: command pulse lasts one cycle
    wr(8'h00, 32'hFFFF_FF5A);
    check("R1 pulse", 32'(cmd), 32'h5A);
    @(negedge clk);
    check("R1 pulse gone", 32'(cmd), 32'h0);
    wr(8'h00, 32'h0);
    check("R1 zero write", 32'(cmd), 32'h0);

    // R6: interrupt gating, mask = 0xF3C
    status = 12'h003; #1;
    check("R6 masked", 32'(irq), 32'h0);
    status = 12'h004; #1;
    check("R6 unmasked", 32'(irq), 32'h1);
    status = 12'h800; #1;
    check("R6 top bit", 32'(irq), 32'h1);
    wr(8'h18, 32'h0000_0FFF);
    check("R5 clear all irq", 32'(irq), 32'h0);
    status = 12'hFFF; #1;
    check("R6 mask zero", 32'(irq), 32'h0);
    wr(8'h14, 32'h0000_0001);
    check("R5 set one irq", 32'(irq), 32'h1);

    // R3: clear all features
    wr(8'h0C, 32'hFFFF_FFFF);
    check("R3 clear all", 32'(feat), 32'h0);

    // R10: reset mid-run
    wr(8'h08, 32'h0000_0011);
    wr(8'h04, 32'h0000_1234);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R10 feat mid", 32'(feat), 32'h0);
    check("R10 mode mid", 32'(mode), 32'h0);
    check("R10 irq mid", 32'(irq), 32'h0);
    rst_n = 1'b1;
    rd(8'h1C, v); check("R10 mask mid", v, 32'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule